// File: doc/BRIEF.md
# Mark/Space Modulation Envelope Generator

This block produces the repeating on/off envelope that keys an infrared-style carrier transmitter. Each modulation cycle starts by loading a down counter from a mark-period buffer. The cycle ends when the counter reaches the value held in an active space-period register. The output is active (mark) while the counter is above that value. At the end of each cycle the counter and the active space register both reload from their buffers. Software can therefore write new periods at any time, and they take effect cleanly at the next cycle boundary.

A small byte-wide register interface gives access to a control/status register and the two period buffers. The control/status register holds these fields:

- a run enable
- an interrupt enable
- an output inversion mode
- a baseband select that bypasses carrier gating
- an extended-space bit that holds the output in space
- a mask bit passed out to neighbouring logic
- a divide-by-two clock select
- a read-only end-of-cycle flag

The flag is cleared by a two-step sequence: a status read, then an access to one of the period buffers. The interrupt output follows the flag when interrupts are enabled. Generating the carrier itself is outside this block; the carrier arrives as an input.

Top module: `mod_env_gen`

## Requirements
- R1: After reset the control/status register, both buffers, `mod_o`, `irq_o` and `ext_mask_o` are all 0.
- R2: Address 0 is the control/status register, address 2 the mark buffer, address 3 the space buffer, address 1 reads 0. Control bits: 0 enable, 1 interrupt enable, 2 mode, 3 baseband, 4 extended space, 5 external mask, 6 divide-by-two, 7 end-of-cycle flag.
- R3: While enable is 0 the counter tracks the buffers and `mod_o` is 0.
- R4: With mark M ≥ space S, starting from the clock after enable is written, the counter decrements once per tick. The envelope is active for M−S ticks, then inactive for 1 tick, repeating with a period of M−S+1 ticks.
- R5: The flag reads 1 from the first clock after the tick on which the counter equals the active space value.
- R6: Buffer writes made during a cycle take effect only at the next end of cycle.
- R7: The flag clears only when a status read (rd at address 0) is immediately followed, as the next bus access, by an access to address 2 or 3. Any other order leaves it set.
- R8: Writes to bit 7 of the control/status register have no effect on the flag.
- R9: With divide-by-two set, a tick occurs every second clock, the first one two clocks after enable.
- R10: With baseband 0, `mod_o` is the envelope ANDed with `carrier_i`. With baseband 1, `mod_o` is the envelope itself.
- R11: With extended space set, `mod_o` stays 0.
- R12: With mode set, the envelope is inverted (active during space).
- R13: `irq_o` is the flag ANDed with the interrupt enable bit.
- R14: `ext_mask_o` follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| carrier_i | input | 1 | Carrier to gate |
| mod_o | output | 1 | Modulated output |
| irq_o | output | 1 | Interrupt |
| ext_mask_o | output | 1 | External mask bit |

## Verification
A register write lands on the rising edge where its strobe is high. The counter, the envelope and `mod_o` reflect that write from the next falling edge onward, which the bench numbers j = 0. The flag and `irq_o` appear one clock after the end-of-cycle tick: at j = P with full-rate ticks, where P = M−S+1, and at j = 2P with divide-by-two. The bench drives inputs at falling edges and samples one time unit later. Its expected values come from closed forms in j, such as counter = M − (j mod P), so every comparison falls in the cycle the formula predicts.

// File: rtl/mod_env_pkg.sv
package mod_env_pkg;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_RSVD  = 2'd1;
  localparam logic [1:0] A_MARK  = 2'd2;
  localparam logic [1:0] A_SPACE = 2'd3;

  // packed MSB first: div2 is bit 6, en is bit 0
  typedef struct packed {
    logic div2;
    logic eimsk;
    logic exspc;
    logic base;
    logic mode;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/mod_env_regs.sv
module mod_env_regs
  import mod_env_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              eoc_set_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] mark_o,
  output logic [DATA_W-1:0] space_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] mark_q, space_q;
  logic              flag_q, armed_q;
  logic              acc, stat_rd, data_acc, clr;
  logic              unused_wbit;

  assign acc      = rd_i | wr_i;
  assign stat_rd  = rd_i & ~wr_i & (addr_i == A_CTRL);
  assign data_acc = acc & addr_i[1];
  assign clr      = data_acc & armed_q;
  assign unused_wbit = ^wdata_i[DATA_W-1:7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mark_q  <= '0;
      space_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[6:0]);
        A_MARK:  mark_q  <= wdata_i;
        A_SPACE: space_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // status read arms; the very next access decides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (acc) armed_q <= stat_rd & flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (eoc_set_i) flag_q <= 1'b1;
    else if (clr)       flag_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = DATA_W'({flag_q, ctrl_q});
      A_MARK:  rdata_o = mark_q;
      A_SPACE: rdata_o = space_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign mark_o  = mark_q;
  assign space_o = space_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/mod_env_presc.sv
module mod_env_presc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div2_i,
  output logic tick_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tog_q <= 1'b0;
    else if (!en_i || !div2_i) tog_q <= 1'b0;
    else                       tog_q <= ~tog_q;
  end

  assign tick_o = en_i & (~div2_i | tog_q);
endmodule

// File: rtl/mod_env_cnt.sv
module mod_env_cnt #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] mark_i,
  input  logic [DATA_W-1:0] space_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              eoc_o,
  output logic              env_o
);
  logic [DATA_W-1:0] cnt_q, sp_q;
  logic              hit;

  assign hit = (cnt_q == sp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sp_q  <= '0;
    end else if (!en_i || (tick_i && hit)) begin
      cnt_q <= mark_i;
      sp_q  <= space_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign eoc_o = en_i & tick_i & hit;
  assign env_o = cnt_q > sp_q;
  assign cnt_o = cnt_q;
  assign sp_o  = sp_q;
endmodule

// File: rtl/mod_env_gen.sv
module mod_env_gen
  import mod_env_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              carrier_i,
  output logic              mod_o,
  output logic              irq_o,
  output logic              ext_mask_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] mark_buf, space_buf, cnt, sp;
  logic              flag, tick, eoc_pulse, env, shaped;

  mod_env_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i,
    .eoc_set_i(eoc_pulse),
    .ctrl_o(ctrl), .mark_o(mark_buf), .space_o(space_buf),
    .flag_o(flag), .rdata_o
  );

  mod_env_presc i_presc (
    .clk_i, .rst_ni, .en_i(ctrl.en), .div2_i(ctrl.div2), .tick_o(tick)
  );

  mod_env_cnt #(.DATA_W(DATA_W)) i_cnt (
    .clk_i, .rst_ni, .en_i(ctrl.en), .tick_i(tick),
    .mark_i(mark_buf), .space_i(space_buf),
    .cnt_o(cnt), .sp_o(sp), .eoc_o(eoc_pulse), .env_o(env)
  );

  always_comb begin
    shaped = ctrl.mode ? ~env : env;
    if (!ctrl.base) shaped = shaped & carrier_i;
    mod_o = ctrl.en & ~ctrl.exspc & shaped;
  end

  assign irq_o      = flag & ctrl.ie;
  assign ext_mask_o = ctrl.eimsk;
endmodule

// File: rtl/mod_env_chk.sv
module mod_env_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic              en,
  input logic              div2,
  input logic              tick,
  input logic              eoc,
  input logic              flag,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] sp,
  input logic [DATA_W-1:0] mark,
  input logic [DATA_W-1:0] space
);
  p_load_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> cnt == $past(mark));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick && cnt != sp) |=> cnt == DATA_W'($past(cnt) - 1'b1));

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc |=> flag);

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc |=> (cnt == $past(mark)) && (sp == $past(space)));

  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past((rd_i || wr_i) && addr_i[1]));

  p_flag_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && !eoc) |=> !flag);

  p_half_rate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && div2 && tick && !(wr_i && addr_i == 2'd0)) |=> !tick);
endmodule

bind mod_env_gen mod_env_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
  .en(ctrl.en), .div2(ctrl.div2), .tick(tick), .eoc(eoc_pulse), .flag(flag),
  .cnt(cnt), .sp(sp), .mark(mark_buf), .space(space_buf)
);

// File: tb/test_mod_env_gen.sv
module test_mod_env_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0, wr = 1'b0, carrier = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          mod_out, irq, ext_mask;
  int            n_cmp = 0, n_err = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_env_gen #(.DATA_W(DW)) i_mod_env_gen (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .carrier_i(carrier),
    .mod_o(mod_out), .irq_o(irq), .ext_mask_o(ext_mask)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek_flag(output int f);
    addr = 2'd0;
    #1 f = int'(rdata[7]);
  endtask

  // disable, load buffers, clear any pending flag
  task automatic prep(input int m, input int s);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, DW'(m));
    bus_wr(2'd3, DW'(s));
    bus_rd(2'd0);
    bus_rd(2'd2);
    addr = 2'd0;
  endtask

  initial begin
    int f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    addr = 2'd0; #1 chk("R1 ctrl", int'(rdata), 0);
    addr = 2'd2; #1 chk("R1 mark", int'(rdata), 0);
    addr = 2'd3; #1 chk("R1 space", int'(rdata), 0);
    chk("R1 mod", int'(mod_out), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ext", int'(ext_mask), 0);
    @(negedge clk);

    // R2 map
    bus_wr(2'd2, 8'hA5);
    bus_wr(2'd3, 8'h3C);
    bus_wr(2'd1, 8'hFF);
    addr = 2'd2; #1 chk("R2 mark rd", int'(rdata), 'hA5);
    addr = 2'd3; #1 chk("R2 space rd", int'(rdata), 'h3C);
    addr = 2'd1; #1 chk("R2 rsvd rd", int'(rdata), 0);
    @(negedge clk);
    bus_wr(2'd0, 8'h7E);
    addr = 2'd0; #1 chk("R2 ctrl rd", int'(rdata), 'h7E);
    @(negedge clk);

    // R14 mask bit
    bus_wr(2'd0, 8'h20);
    #1 chk("R14 mask on", int'(ext_mask), 1);
    @(negedge clk);
    bus_wr(2'd0, 8'h00);
    #1 chk("R14 mask off", int'(ext_mask), 0);
    @(negedge clk);

    // R3 disabled: output idle, counter tracks buffers
    prep(5, 2);
    bus_wr(2'd0, 8'h08);
    for (int j = 0; j < 4; j++) begin
      #1 chk("R3 idle", int'(mod_out), 0);
      @(negedge clk);
    end

    // R4/R5 sweep of mark/space pairs, baseband
    for (int m = 0; m <= 5; m++) begin
      for (int s = 0; s <= m; s++) begin
        int p;
        p = m - s + 1;
        prep(m, s);
        bus_wr(2'd0, 8'h09);
        for (int j = 0; j < 2 * p + 2; j++) begin
          #1 chk("R4 envelope", int'(mod_out), int'((m - (j % p)) > s));
          if (j == p - 1) chk("R5 flag before", int'(rdata[7]), 0);
          if (j == p) chk("R5 flag after", int'(rdata[7]), 1);
          @(negedge clk);
        end
      end
    end

    // R6 double buffering: new mark written mid-cycle
    prep(4, 1);
    bus_wr(2'd0, 8'h09);
    #1 chk("R6 j0", int'(mod_out), 1);
    bus_wr(2'd2, 8'd6);
    for (int j = 1; j < 13; j++) begin
      int e;
      e = (j < 4) ? int'((4 - j) > 1) : int'((6 - ((j - 4) % 6)) > 1);
      #1 chk("R6 reload", int'(mod_out), e);
      @(negedge clk);
    end

    // R9 divide-by-two
    prep(3, 1);
    bus_wr(2'd0, 8'h49);
    for (int j = 0; j < 14; j++) begin
      #1 chk("R9 half rate", int'(mod_out), int'((3 - ((j / 2) % 3)) > 1));
      if (j == 5) chk("R9 flag before", int'(rdata[7]), 0);
      if (j == 6) chk("R9 flag after", int'(rdata[7]), 1);
      @(negedge clk);
    end

    // R10 carrier gating
    prep(3, 0);
    bus_wr(2'd0, 8'h01);
    carrier = 1'b0; #1 chk("R10 carrier low", int'(mod_out), 0);
    carrier = 1'b1; #1 chk("R10 carrier high", int'(mod_out), 1);
    @(negedge clk);
    carrier = 1'b0;

    // R11 extended space
    prep(3, 1);
    bus_wr(2'd0, 8'h19);
    for (int j = 0; j < 6; j++) begin
      #1 chk("R11 forced space", int'(mod_out), 0);
      @(negedge clk);
    end

    // R12 inverted mode
    prep(3, 1);
    bus_wr(2'd0, 8'h0D);
    for (int j = 0; j < 6; j++) begin
      #1 chk("R12 inverted", int'(mod_out), int'(!((3 - (j % 3)) > 1)));
      @(negedge clk);
    end

    // R13 interrupt
    prep(2, 1);
    bus_wr(2'd0, 8'h0B);
    #1 chk("R13 irq idle", int'(irq), 0);
    @(negedge clk);
    @(negedge clk);
    #1 chk("R13 irq set", int'(irq), 1);
    bus_wr(2'd0, 8'h09);
    #1 chk("R13 irq masked", int'(irq), 0);
    chk("R13 flag kept", int'(rdata[7]), 1);

    // R8 bit 7 write ignored
    bus_wr(2'd0, 8'h00);
    peek_flag(f); chk("R8 write 0 keeps flag", f, 1);
    bus_rd(2'd0);
    bus_rd(2'd3);
    bus_wr(2'd0, 8'h80);
    peek_flag(f); chk("R8 write 1 no set", f, 0);
    #1 chk("R8 ctrl value", int'(rdata), 0);

    // R7 clear sequence ordering
    prep(1, 1);
    bus_wr(2'd0, 8'h09);
    @(negedge clk);
    bus_wr(2'd0, 8'h00);
    peek_flag(f); chk("R7 flag set", f, 1);
    bus_wr(2'd2, 8'd1);
    peek_flag(f); chk("R7 data without read", f, 1);
    bus_rd(2'd0);
    bus_rd(2'd1);
    bus_rd(2'd3);
    peek_flag(f); chk("R7 read then other", f, 1);
    bus_rd(2'd0);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd3, 8'd1);
    peek_flag(f); chk("R7 read then ctrl write", f, 1);
    bus_rd(2'd0);
    bus_wr(2'd3, 8'd2);
    peek_flag(f); chk("R7 proper clear", f, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule